// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sleep and Wake-Up

This block recovers data words from an asynchronous serial line. A clock enable pulses sixteen times per bit period. The receiver hunts for a falling edge and qualifies the start bit at its centre. It then decides every following bit by a three-sample majority vote. A frame holds either eight or nine data bits, sent least significant bit first, followed by one stop bit. When parity checking is on, the top data position carries the parity bit. An even or odd check is then made over all data positions.

Received words are offered through a ready flag and taken with a one-cycle take pulse. The receiver reports overrun, framing error, parity error and idle line. The idle line condition is a full frame length of ones. It is counted either from any one bit, or only from ones that follow a stop bit.

A sleep request puts the receiver into a mode in which frames load nothing and set no flags. The receiver leaves sleep on its own on the selected wake event. That event is either an idle line or an address-mark frame. Two interrupt request outputs gate the status with per-source enables.

Top module: `uart_wake_rx`

## Requirements
- R1: `wide_frame`=0 gives 8 data bits and `wide_frame`=1 gives 9 data bits, received least significant bit first. At the stop-bit decision the word appears on `rx_word` with `word_ready`=1. Bit 8 of `rx_word` is 0 in 8-bit mode.
- R2: Each bit is the majority of the line samples at sub-bit ticks 7, 8 and 9 of its 16 ticks, so one corrupted sample does not change it. A low pulse that is gone at the start-bit centre loads nothing.
- R3: With `parity_on`=1, the top data position carries parity and is kept in `rx_word`. `parity_err` sets when the XOR of all data positions differs from `parity_odd` (0 even, 1 odd). With `parity_on`=0, `parity_err` stays 0.
- R4: A stop bit sampled as 0 sets `frame_err` together with the loaded word.
- R5: A frame that completes while `word_ready`=1 sets `overrun` and leaves `rx_word` unchanged.
- R6: A `data_take` pulse clears `word_ready`, `overrun`, `frame_err`, `parity_err` and `line_idle` on the next clock edge.
- R7: The idle count needs 10 (8-bit) or 11 (9-bit) consecutive one bit times. With `idle_after_stop`=0, trailing one data bits and the stop bit count. With `idle_after_stop`=1, the count begins after the stop bit.
- R8: `line_idle` sets at most once per idle period. It is armed again only by a completed frame, and it is cleared when a valid start bit is qualified.
- R9: A `sleep_req` pulse sets `sleeping`. While asleep, frames change neither `rx_word` nor any receive flag, and `line_idle` does not set.
- R10: With `wake_on_mark`=0, an idle detection clears `sleeping` without setting `line_idle`.
- R11: With `wake_on_mark`=1, a frame whose last data bit is 1 clears `sleeping` and is loaded as a normal word. A frame whose last data bit is 0, or an idle line, leaves the receiver asleep.
- R12: `rx_irq` = `rx_irq_en` and (`word_ready` or `overrun`). `idle_irq` = `idle_irq_en` and `line_idle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Sixteen-times oversampling enable |
| ser_in | input | 1 | Serial line, idle high |
| wide_frame | input | 1 | 0: 8 data bits, 1: 9 data bits |
| parity_on | input | 1 | Enable parity check |
| parity_odd | input | 1 | 0 even, 1 odd parity |
| idle_after_stop | input | 1 | Idle count begins only after a stop bit |
| wake_on_mark | input | 1 | 0 wake on idle, 1 wake on address mark |
| sleep_req | input | 1 | Pulse to enter sleep |
| data_take | input | 1 | Pulse to take the word and clear flags |
| rx_irq_en | input | 1 | Receive interrupt enable |
| idle_irq_en | input | 1 | Idle interrupt enable |
| rx_word | output | 9 | Last loaded word |
| word_ready | output | 1 | Word waiting to be taken |
| overrun | output | 1 | A frame was lost to a full buffer |
| frame_err | output | 1 | Stop bit of loaded word was 0 |
| parity_err | output | 1 | Parity of loaded word was wrong |
| line_idle | output | 1 | Idle line detected |
| sleeping | output | 1 | Receiver in sleep |
| rx_irq | output | 1 | Receive interrupt request |
| idle_irq | output | 1 | Idle interrupt request |

## Verification
The hardest state to reach from the ports is a sleeping receiver that has to tell apart the events that must not wake it from the one that must. A frame without the mark bit and an idle line should leave it asleep, and only a marked frame should wake it. The bench therefore first ends an idle period so that the idle logic is disarmed. It then requests sleep and sends an unmarked frame, which re-arms the idle logic. It lets a full idle period pass and only then sends the marked frame. Throughout this sequence the reference model predicts, cycle by cycle, whether the idle event is consumed and when the receiver leaves sleep.

// File: rtl/uart_wake_rx.sv
module uart_wake_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       ser_in,
  input  logic       wide_frame,
  input  logic       parity_on,
  input  logic       parity_odd,
  input  logic       idle_after_stop,
  input  logic       wake_on_mark,
  input  logic       sleep_req,
  input  logic       data_take,
  input  logic       rx_irq_en,
  input  logic       idle_irq_en,
  output logic [8:0] rx_word,
  output logic       word_ready,
  output logic       overrun,
  output logic       frame_err,
  output logic       parity_err,
  output logic       line_idle,
  output logic       sleeping,
  output logic       rx_irq,
  output logic       idle_irq
);
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2;

  typedef enum logic [1:0] {HUNT, START, DATA, STOP} st_t;

  st_t           st;
  logic [CW-1:0] sub;
  logic [3:0]    idx;
  logic [8:0]    sh;
  logic          par;
  logic          s_a, s_b;
  logic [3:0]    icnt;
  logic          armed;

  wire [3:0] nbits    = wide_frame ? 4'd9 : 4'd8;
  wire [3:0] ilim     = nbits + 4'd2;
  wire       vote     = (s_a & s_b) | (s_a & ser_in) | (s_b & ser_in);
  wire       dec      = os_tick && sub == CW'(MID + 1);
  wire       wrap     = os_tick && sub == CW'(OVS - 1);
  wire       last_bit = wide_frame ? sh[8] : sh[7];
  wire       par_bad  = parity_on && (par != parity_odd);
  wire       done     = st == STOP && dec;
  wire       mark_wk  = done && sleeping && wake_on_mark && last_bit;
  wire       take     = done && (!sleeping || mark_wk);
  wire       start_ok = st == START && dec && !vote;
  wire       idle_hit = st == HUNT && wrap && ser_in && armed && icnt == ilim - 4'd1;
  wire [3:0] icnt_bit = (!idle_after_stop && vote) ? icnt + 4'd1 : 4'd0;

  assign rx_irq   = rx_irq_en & (word_ready | overrun);
  assign idle_irq = idle_irq_en & line_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_a <= 1'b1;
      s_b <= 1'b1;
    end else if (os_tick) begin
      if (sub == CW'(MID - 1)) s_a <= ser_in;
      if (sub == CW'(MID))     s_b <= ser_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= HUNT;
      sub  <= '0;
      idx  <= '0;
      sh   <= '0;
      par  <= 1'b0;
      icnt <= '0;
    end else if (os_tick) begin
      sub <= wrap ? '0 : sub + CW'(1);
      case (st)
        HUNT: begin
          if (!ser_in) begin
            st  <= START;
            sub <= '0;
          end else if (wrap && icnt != ilim) begin
            icnt <= icnt + 4'd1;
          end
        end
        START: begin
          if (dec) begin
            icnt <= '0;
            if (vote) begin
              st  <= HUNT;
              sub <= '0;
            end else begin
              sh  <= '0;
              par <= 1'b0;
              idx <= '0;
            end
          end
          if (wrap) st <= DATA;
        end
        DATA: begin
          if (dec) begin
            sh[idx] <= vote;
            par     <= par ^ vote;
            idx     <= idx + 4'd1;
            icnt    <= icnt_bit;
          end
          if (wrap && idx == nbits) st <= STOP;
        end
        default: begin
          if (dec) begin
            st   <= HUNT;
            sub  <= '0;
            icnt <= icnt_bit;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word    <= '0;
      word_ready <= 1'b0;
      overrun    <= 1'b0;
      frame_err  <= 1'b0;
      parity_err <= 1'b0;
      line_idle  <= 1'b0;
      sleeping   <= 1'b0;
      armed      <= 1'b0;
    end else begin
      if (data_take) begin
        word_ready <= 1'b0;
        overrun    <= 1'b0;
        frame_err  <= 1'b0;
        parity_err <= 1'b0;
        line_idle  <= 1'b0;
      end
      if (sleep_req) sleeping <= 1'b1;
      if (start_ok) line_idle <= 1'b0;
      if (done) armed <= 1'b1;
      if (mark_wk) sleeping <= 1'b0;
      if (take) begin
        if (word_ready) begin
          overrun <= 1'b1;
        end else begin
          rx_word    <= wide_frame ? sh : {1'b0, sh[7:0]};
          word_ready <= 1'b1;
          frame_err  <= ~vote;
          parity_err <= par_bad;
        end
      end
      if (idle_hit) begin
        armed <= 1'b0;
        if (sleeping) begin
          if (!wake_on_mark) sleeping <= 1'b0;
        end else begin
          line_idle <= 1'b1;
        end
      end
    end
  end
endmodule

module uart_wake_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic data_take,
  input logic rx_irq_en,
  input logic idle_irq_en,
  input logic word_ready,
  input logic overrun,
  input logic line_idle,
  input logic sleeping,
  input logic rx_irq,
  input logic idle_irq
);
  p_ready_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready && !data_take |=> word_ready);
  p_take_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_take |=> !word_ready && !overrun);
  p_ovr_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(word_ready));
  p_sleep_load_wakes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_ready) && $past(sleeping) |-> !sleeping);
  p_idle_not_asleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_idle) |-> !$past(sleeping));
  p_idle_irq_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    idle_irq |-> line_idle && idle_irq_en);
  p_rx_irq_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_irq_en |-> !rx_irq);
endmodule

bind uart_wake_rx uart_wake_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .data_take(data_take), .rx_irq_en(rx_irq_en),
  .idle_irq_en(idle_irq_en), .word_ready(word_ready), .overrun(overrun),
  .line_idle(line_idle), .sleeping(sleeping), .rx_irq(rx_irq), .idle_irq(idle_irq)
);

// File: tb/uart_wake_rx_tb_top.sv
module uart_wake_rx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0, ser_in = 1'b1;
  logic wide_frame = 1'b0, parity_on = 1'b0, parity_odd = 1'b0, idle_after_stop = 1'b0;
  logic wake_on_mark = 1'b0, sleep_req = 1'b0, data_take = 1'b0;
  logic rx_irq_en = 1'b1, idle_irq_en = 1'b1;
  logic [8:0] rx_word;
  logic word_ready, overrun, frame_err, parity_err, line_idle, sleeping, rx_irq, idle_irq;

  uart_wake_rx dut_i (.*);

  always #5 clk = ~clk;

  typedef struct {int t; logic [8:0] d; logic stop; logic pbad; logic mark; int c0;} fr_t;
  fr_t fq[$];
  int  sq[$];

  int cyc = 0, checks = 0, failures = 0, idle_due = -1;
  logic p_take = 1'b0, p_sleep = 1'b0, chk_on = 1'b0, finished = 1'b0;
  logic m_full = 0, m_ovr = 0, m_fe = 0, m_pe = 0, m_idle = 0, m_sleep = 0, m_armed = 0, idle_known = 1;
  logic [8:0] m_data = '0;

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    p_take  <= data_take;
    p_sleep <= sleep_req;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  function automatic int ilim();
    return wide_frame ? 11 : 10;
  endfunction

  always @(negedge clk) begin
    if (chk_on) begin
      if (p_take) begin
        m_full = 0; m_ovr = 0; m_fe = 0; m_pe = 0; m_idle = 0;
      end
      if (p_sleep) m_sleep = 1;
      if (sq.size() > 0 && sq[0] == cyc) begin
        void'(sq.pop_front());
        m_idle = 0;
        idle_known = 1;
      end
      if (fq.size() > 0 && fq[0].t == cyc) begin
        fr_t f;
        f = fq.pop_front();
        m_armed = 1;
        if (!m_sleep || (wake_on_mark && f.mark)) begin
          m_sleep = 0;
          if (m_full) m_ovr = 1;
          else begin
            m_data = f.d; m_full = 1; m_fe = !f.stop; m_pe = f.pbad;
          end
        end
        if (!f.stop) begin
          idle_known = 0;
          idle_due = -1;
        end else idle_due = cyc + 16 * (ilim() - f.c0);
      end
      if (idle_due == cyc) begin
        idle_due = -1;
        if (m_armed) begin
          m_armed = 0;
          if (m_sleep) begin
            if (!wake_on_mark) m_sleep = 0;
          end else m_idle = 1;
        end
      end
      check("R1", "word_ready", word_ready, m_full);
      if (m_full) check("R1", "rx_word", rx_word, m_data);
      check("R5", "overrun", overrun, m_ovr);
      check("R4", "frame_err", frame_err, m_fe);
      check("R3", "parity_err", parity_err, m_pe);
      check("R9", "sleeping", sleeping, m_sleep);
      check("R12", "rx_irq", rx_irq, rx_irq_en & (m_full | m_ovr));
      if (idle_known) begin
        check("R7", "line_idle", line_idle, m_idle);
        check("R12", "idle_irq", idle_irq, idle_irq_en & m_idle);
      end
    end
  end

  task automatic send(input logic [8:0] d, input logic stop, input int gb, input int goff);
    int n, k, c0;
    logic [8:0] mask;
    fr_t f;
    n = wide_frame ? 9 : 8;
    mask = wide_frame ? 9'h1FF : 9'h0FF;
    @(negedge clk);
    k = cyc + 1;
    if (idle_due >= k) idle_due = -1;
    c0 = 0;
    if (!idle_after_stop) begin
      c0 = 1;
      for (int i = n - 1; i >= 0; i--) begin
        if (!d[i]) break;
        c0++;
      end
    end
    f.t = k + 10 + 16 * (n + 1);
    f.d = d & mask;
    f.stop = stop;
    f.pbad = parity_on && ((^(d & mask)) != parity_odd);
    f.mark = d[n-1];
    f.c0 = c0;
    sq.push_back(k + 10);
    fq.push_back(f);
    for (int b = 0; b <= n + 1; b++) begin
      logic v;
      v = (b == 0) ? 1'b0 : (b <= n) ? d[b-1] : stop;
      for (int c = 0; c < 16; c++) begin
        ser_in = (b == gb && c == goff) ? ~v : v;
        @(negedge clk);
      end
    end
    ser_in = 1'b1;
  endtask

  task automatic false_start();
    int k;
    @(negedge clk);
    k = cyc + 1;
    if (idle_due >= k) idle_due = k + 10 + 16 * ilim();
    ser_in = 1'b0;
    repeat (4) @(negedge clk);
    ser_in = 1'b1;
  endtask

  task automatic take_word();
    @(negedge clk); data_take = 1'b1;
    @(negedge clk); data_take = 1'b0;
  endtask

  task automatic go_sleep();
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    os_tick = 1'b1;
    @(negedge clk);
    check("R1", "reset word_ready", word_ready, 0);
    check("R9", "reset sleeping", sleeping, 0);
    check("R7", "reset line_idle", line_idle, 0);
    chk_on = 1'b1;

    // R1 R7 short idle counting from trailing ones, R6 take clears idle
    send(9'h0A5, 1'b1, -1, 0);
    wait_cyc(200);
    check("R7", "idle after short count", line_idle, 1);
    take_word();
    // R5 overrun on back-to-back frames
    send(9'h03C, 1'b1, -1, 0);
    send(9'h05A, 1'b1, -1, 0);
    wait_cyc(20);
    check("R5", "overrun set", overrun, 1);
    check("R5", "first word kept", rx_word, 9'h03C);
    wait_cyc(200);
    take_word();
    // R2 single corrupted sample and a false start
    send(9'h00F, 1'b1, 3, 9);
    wait_cyc(200);
    take_word();
    false_start();
    wait_cyc(250);
    check("R2", "false start loads nothing", word_ready, 0);
    // R8 idle stays clear with no new frame
    take_word();
    wait_cyc(250);
    check("R8", "no second idle", line_idle, 0);
    // R3 parity even and odd
    parity_on = 1'b1;
    send(9'h003, 1'b1, -1, 0); wait_cyc(200); take_word();
    send(9'h083, 1'b1, -1, 0); wait_cyc(20);
    check("R3", "even parity error", parity_err, 1);
    wait_cyc(180); take_word();
    parity_odd = 1'b1;
    send(9'h083, 1'b1, -1, 0); wait_cyc(200); take_word();
    parity_on = 1'b0;
    // R1 nine-bit frames
    wide_frame = 1'b1;
    send(9'h1A5, 1'b1, -1, 0); wait_cyc(220); take_word();
    send(9'h155, 1'b1, -1, 0); wait_cyc(220); take_word();
    wide_frame = 1'b0;
    // R4 framing error
    send(9'h055, 1'b0, -1, 0);
    wait_cyc(20);
    check("R4", "frame_err set", frame_err, 1);
    wait_cyc(200); take_word();
    // R7 long idle counting after stop only
    idle_after_stop = 1'b1;
    send(9'h0FF, 1'b1, -1, 0); wait_cyc(250); take_word();
    idle_after_stop = 1'b0;
    // R9 R10 sleep, ignored frame, wake on idle
    go_sleep();
    send(9'h012, 1'b1, -1, 0);
    wait_cyc(20);
    check("R9", "asleep frame ignored", word_ready, 0);
    wait_cyc(230);
    check("R10", "woken by idle", sleeping, 0);
    send(9'h034, 1'b1, -1, 0); wait_cyc(200); take_word();
    // R11 wake on address mark
    wake_on_mark = 1'b1;
    go_sleep();
    send(9'h012, 1'b1, -1, 0);
    wait_cyc(250);
    check("R11", "still asleep after idle", sleeping, 1);
    send(9'h092, 1'b1, -1, 0);
    wait_cyc(20);
    check("R11", "marked word loaded", rx_word, 9'h092);
    wait_cyc(200); take_word();
    wake_on_mark = 1'b0;
    // R12 enables gate requests
    rx_irq_en = 1'b0; idle_irq_en = 1'b0;
    send(9'h044, 1'b1, -1, 0); wait_cyc(200);
    check("R12", "rx_irq masked", rx_irq, 0);
    check("R12", "idle_irq masked", idle_irq, 0);
    take_word();
    rx_irq_en = 1'b1; idle_irq_en = 1'b1;
    wait_cyc(10);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule